// File: doc/BRIEF.md
# Serial Memory Status Register Front End

This block is the status-register portion of a serial-memory slave that uses SPI mode 0. It runs on a system clock and oversamples the chip-select, serial-clock and serial-data-in pins. It decodes three command codes. The first sets a write-enable flag. The second streams the status byte back to the host. The third replaces the protection fields of the status byte. A committed status write starts a busy interval of fixed length, counted in system clocks. During that interval the host can poll the status byte to see when the write is complete.

Two pins can block or delay changes. A write-protect pin prevents status writes while the status-write-disable bit is set. An active-low reset pin clears the write-enable flag and drops any frame in progress. A reset that arrives during the busy interval does not cut the interval short. It takes effect once the interval has ended. The memory array, program and erase commands, and the decoding of protected addresses are handled elsewhere.

Top module: `spiStatusFront`

## Requirements
- R1: Command code 0x06 sets the write-enable flag (status bit 1) only when chip select rises after exactly 8 bits. A frame with any code other than 0x06, 0x05 or 0x01 changes nothing and leaves misoEn low.
- R2: Command code 0x05 shifts the status byte out on miso, most significant bit first. The bits are {bit7 write-disable, bits 6:5 always 0, bits 4:2 block-protect, bit1 write-enable, bit0 busy}. The byte repeats every 8 clocks until chip select rises, and each repeat is resampled.
- R3: Command code 0x01 followed by a data byte loads data bit 7 into status bit 7 and data bits 4:2 into status bits 4:2. It does this only when the write-enable flag is 1. Without the flag the frame is ignored. Data bits 6:5 and 1:0 have no effect.
- R4: A status write frame takes effect only if chip select rises after exactly 16 bits. With any other bit count the frame is discarded and the write-enable flag is kept.
- R5: When status bit 7 is 1 and wpN is low, a status write is rejected and both the status byte and the write-enable flag stay as they were. When status bit 7 is 0, wpN has no effect.
- R6: A committed status write holds status bit 0 at 1 for exactly WRITE_CYCLES system clocks. The status byte stays readable during that time.
- R7: The write-enable flag clears in the same cycle that status bit 0 returns to 0.
- R8: While status bit 0 is 1, only the read command is decoded. Write-enable and status-write frames are ignored.
- R9: misoEn is 1 only in the data phase of a read frame. It is 0 while chip select is high.
- R10: A low level on hwRstN while no write is busy does three things. It clears the write-enable flag, drops the current frame and holds misoEn at 0. It keeps status bits 7 and 4:2.
- R11: A low level on hwRstN during the busy interval lets the interval and its committed value complete. The reset takes effect after the interval ends.
- R12: After sysRstN the status byte reads 0x00 and misoEn is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous power-on reset, active low |
| csN | input | 1 | Chip select from host, active low |
| sck | input | 1 | Serial clock from host, idle low |
| mosi | input | 1 | Serial data from host |
| wpN | input | 1 | Write-protect pin, active low |
| hwRstN | input | 1 | Reset pin, active low, deferred while busy |
| miso | output | 1 | Serial data to host |
| misoEn | output | 1 | Output enable for miso; 0 means high impedance |

## Verification
The bench builds the block with WRITE_CYCLES set to 600 system clocks and uses a serial-clock half period of 8 system clocks. With these values a complete 16-bit read frame fits inside one busy interval. That makes it possible to poll the busy and write-enable bits mid-cycle, to send a second status write while the first is still busy, and to hold the reset pin low across a busy interval. The data byte is swept over every combination of the four writable bits, with the ignored bits toggled in each case. The exact length of the busy interval is counted cycle by cycle in the checker.

// File: rtl/spiStatusPkg.sv
package spiStatusPkg;

  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_RDSR = 8'h05;
  localparam logic [7:0] CMD_WRSR = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WEN, ST_WRDATA, ST_READ, ST_SKIP, ST_DEAD
  } fsmState_t;

  typedef struct packed {
    logic setWel;
    logic clearWel;
    logic commitWr;
    logic readActive;
  } ctrlStrobes_t;

endpackage

// File: rtl/spiStatusFsm.sv
module spiStatusFsm
  import spiStatusPkg::*;
(
  input  logic         clk,
  input  logic         sysRstN,
  input  logic         csLow,
  input  logic         csRise,
  input  logic [4:0]   bitCnt,
  input  logic [7:0]   rxByte,
  input  logic         wel,
  input  logic         wip,
  input  logic         srwd,
  input  logic         wpLow,
  input  logic         hwRstLow,
  output ctrlStrobes_t strb
);

  fsmState_t st, nxt;
  logic rstPend;
  logic resetActive;
  logic writeAllowed;

  assign resetActive  = (hwRstLow | rstPend) & ~wip;
  assign writeAllowed = wel & ~wip & ~(srwd & wpLow);

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      st      <= ST_IDLE;
      rstPend <= 1'b0;
    end else begin
      st      <= nxt;
      rstPend <= wip & (hwRstLow | rstPend);
    end
  end

  always_comb begin
    nxt = st;
    strb = '0;
    strb.clearWel   = resetActive;
    strb.readActive = (st == ST_READ);
    if (resetActive) begin
      nxt = ST_DEAD;
    end else begin
      unique case (st)
        ST_IDLE: if (csLow) nxt = ST_CMD;
        ST_CMD: begin
          if (csRise) nxt = ST_IDLE;
          else if (bitCnt == 5'd8) begin
            if (rxByte == CMD_RDSR)      nxt = ST_READ;
            else if (wip)                nxt = ST_SKIP;
            else if (rxByte == CMD_WREN) nxt = ST_WEN;
            else if (rxByte == CMD_WRSR) nxt = ST_WRDATA;
            else                         nxt = ST_SKIP;
          end
        end
        ST_WEN: if (csRise) begin
          strb.setWel = (bitCnt == 5'd8) & ~wip;
          nxt = ST_IDLE;
        end
        ST_WRDATA: if (csRise) begin
          strb.commitWr = (bitCnt == 5'd16) & writeAllowed;
          nxt = ST_IDLE;
        end
        ST_READ, ST_SKIP: if (csRise) nxt = ST_IDLE;
        ST_DEAD: if (!csLow) nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spiStatusDp.sv
module spiStatusDp
  import spiStatusPkg::*;
#(
  parameter int WRITE_CYCLES = 64
) (
  input  logic         clk,
  input  logic         sysRstN,
  input  logic         csN,
  input  logic         sck,
  input  logic         mosi,
  input  logic         wpN,
  input  logic         hwRstN,
  input  ctrlStrobes_t strb,
  output logic         csLow,
  output logic         csRise,
  output logic [4:0]   bitCnt,
  output logic [7:0]   rxByte,
  output logic         wel,
  output logic         wip,
  output logic         srwd,
  output logic         wpLow,
  output logic         hwRstLow,
  output logic [7:0]   statusByte,
  output logic         miso
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [2:0] csQ, sckQ;
  logic [1:0] mosiQ, wpQ, rstQ;
  logic sckRise, sckFall;
  logic [2:0] bp;
  logic [CW-1:0] busyCnt;
  logic [7:0] outShift;
  logic [2:0] outCnt;
  logic busyLast;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      csQ   <= 3'b111;
      sckQ  <= 3'b000;
      mosiQ <= 2'b00;
      wpQ   <= 2'b11;
      rstQ  <= 2'b11;
    end else begin
      csQ   <= {csQ[1:0], csN};
      sckQ  <= {sckQ[1:0], sck};
      mosiQ <= {mosiQ[0], mosi};
      wpQ   <= {wpQ[0], wpN};
      rstQ  <= {rstQ[0], hwRstN};
    end
  end

  assign csLow    = ~csQ[1];
  assign csRise   = csQ[1] & ~csQ[2];
  assign sckRise  = sckQ[1] & ~sckQ[2];
  assign sckFall  = ~sckQ[1] & sckQ[2];
  assign wpLow    = ~wpQ[1];
  assign hwRstLow = ~rstQ[1];
  assign busyLast = wip && (busyCnt == CW'(1));

  assign statusByte = {srwd, 2'b00, bp, wel, wip};
  assign miso       = outShift[7];

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else begin
      if (!csLow) bitCnt <= '0;
      else if (sckRise && bitCnt != 5'd31) bitCnt <= bitCnt + 5'd1;
      if (sckRise) rxByte <= {rxByte[6:0], mosiQ[1]};
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      outShift <= '0;
      outCnt   <= '0;
    end else if (!strb.readActive) begin
      outCnt <= '0;
    end else if (sckFall) begin
      outShift <= (outCnt == 3'd0) ? statusByte : {outShift[6:0], 1'b0};
      outCnt   <= outCnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      srwd    <= 1'b0;
      bp      <= '0;
      wip     <= 1'b0;
      busyCnt <= '0;
    end else if (strb.commitWr) begin
      srwd    <= rxByte[7];
      bp      <= rxByte[4:2];
      wip     <= 1'b1;
      busyCnt <= CW'(WRITE_CYCLES);
    end else if (wip) begin
      busyCnt <= busyCnt - 1'b1;
      if (busyLast) wip <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)          wel <= 1'b0;
    else if (strb.clearWel) wel <= 1'b0;
    else if (strb.setWel)   wel <= 1'b1;
    else if (busyLast)      wel <= 1'b0;
  end

endmodule

// File: rtl/spiStatusFront.sv
module spiStatusFront
  import spiStatusPkg::*;
#(
  parameter int WRITE_CYCLES = 64
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic wpN,
  input  logic hwRstN,
  output logic miso,
  output logic misoEn
);

  ctrlStrobes_t strb;
  logic csLow, csRise, wel, wip, srwd, wpLow, hwRstLow;
  logic [4:0] bitCnt;
  logic [7:0] rxByte, statusByte;

  spiStatusDp #(.WRITE_CYCLES(WRITE_CYCLES)) dp_i (
    .clk(clk), .sysRstN(sysRstN), .csN(csN), .sck(sck), .mosi(mosi),
    .wpN(wpN), .hwRstN(hwRstN), .strb(strb), .csLow(csLow), .csRise(csRise),
    .bitCnt(bitCnt), .rxByte(rxByte), .wel(wel), .wip(wip), .srwd(srwd),
    .wpLow(wpLow), .hwRstLow(hwRstLow), .statusByte(statusByte), .miso(miso)
  );

  spiStatusFsm fsm_i (
    .clk(clk), .sysRstN(sysRstN), .csLow(csLow), .csRise(csRise),
    .bitCnt(bitCnt), .rxByte(rxByte), .wel(wel), .wip(wip), .srwd(srwd),
    .wpLow(wpLow), .hwRstLow(hwRstLow), .strb(strb)
  );

  assign misoEn = strb.readActive;

endmodule

// File: rtl/spiStatusChecker.sv
module spiStatusChecker #(
  parameter int CYCLES = 64
) (
  input logic       clk,
  input logic       sysRstN,
  input logic       csN,
  input logic       misoEn,
  input logic       wip,
  input logic       wel,
  input logic       commitWr,
  input logic [3:0] protBits
);

  int runLen;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) runLen <= 0;
    else if (wip) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R9
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !misoEn);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(wip) |-> $past(commitWr));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    $fell(wip) |-> (runLen == CYCLES));

  // R7
  wel_drop_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    $fell(wip) |-> !wel);

  // R3
  commit_gate_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    commitWr |-> (wel && !wip));

  // R3
  prot_hold_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !$past(commitWr) |-> $stable(protBits));

endmodule

bind spiStatusFront spiStatusChecker #(.CYCLES(WRITE_CYCLES)) chk_i (
  .clk(clk), .sysRstN(sysRstN), .csN(csN), .misoEn(misoEn),
  .wip(statusByte[0]), .wel(statusByte[1]), .commitWr(strb.commitWr),
  .protBits({statusByte[7], statusByte[4:2]})
);

// File: tb/spiStatusFront_tb_top.sv
module spiStatusFront_tb_top;

  localparam int CYC  = 600;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic sysRstN = 1'b0, csN = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic wpN = 1'b1, hwRstN = 1'b1;
  logic miso, misoEn;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spiStatusFront #(.WRITE_CYCLES(CYC)) dut_i (
    .clk(clk), .sysRstN(sysRstN), .csN(csN), .sck(sck), .mosi(mosi),
    .wpN(wpN), .hwRstN(hwRstN), .miso(miso), .misoEn(misoEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] word, input int nbits,
                       output logic [31:0] got, output logic enAny, output logic enData);
    got = '0; enAny = 1'b0; enData = 1'b1;
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[nbits-1-i];
      repeat (HALF) @(negedge clk);
      got = {got[30:0], miso};
      enAny = enAny | misoEn;
      if (i >= 8) enData = enData & misoEn;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic readSr(output logic [7:0] sr, output logic en);
    logic [31:0] g; logic a;
    frame(32'h0500, 16, g, a, en);
    sr = g[7:0];
  endtask

  task automatic wren();
    logic [31:0] g; logic a, e;
    frame(32'h06, 8, g, a, e);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [31:0] g; logic a, e;
    frame({16'h0, 8'h01, d}, 16, g, a, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] sr, d, prot;
    logic en, enA;
    logic [31:0] g;
    repeat (5) @(negedge clk);
    sysRstN = 1'b1;
    repeat (5) @(negedge clk);

    chk("R12 misoEn after reset", misoEn, 0);
    readSr(sr, en);
    chk("R12 status after reset", sr, 8'h00);
    chk("R2 misoEn in read data phase", en, 1);

    // R3: write without write-enable is ignored
    wrsr(8'h9C);
    repeat (CYC + 20) @(negedge clk);
    readSr(sr, en);
    chk("R3 write without enable", sr, 8'h00);

    // R1: 9-bit enable frame does not set the flag; unknown code is inert
    frame(32'h0C, 9, g, enA, en);
    readSr(sr, en);
    chk("R1 enable with 9 bits", sr, 8'h00);
    frame(32'hABFF, 16, g, enA, en);
    chk("R1 unknown code misoEn", enA, 0);
    readSr(sr, en);
    chk("R1 unknown code status", sr, 8'h00);

    prot = 8'h00;
    for (int k = 0; k < 32; k++) begin
      d = {k[3], k[4], k[4], k[2:0], k[4], ~k[4]};
      wren();
      readSr(sr, en);
      chk("R1 enable flag set", sr, prot | 8'h02);
      wrsr(d);
      readSr(sr, en);
      chk("R6 busy and enable during cycle", sr & 8'h03, 8'h03);
      repeat (CYC) @(negedge clk);
      prot = {d[7], 2'b00, d[4:2], 2'b00};
      readSr(sr, en);
      chk("R3 R7 committed value", sr, prot);
    end

    // R4: wrong bit counts (prot is 0x9C here)
    wren();
    frame(32'h0080, 15, g, enA, en);
    readSr(sr, en);
    chk("R4 15-bit write discarded", sr, prot | 8'h02);
    frame(32'h00200, 17, g, enA, en);
    readSr(sr, en);
    chk("R4 17-bit write discarded", sr, prot | 8'h02);

    // R8: second write during busy is ignored
    wrsr(8'h00);
    wrsr(8'h9C);
    repeat (CYC) @(negedge clk);
    readSr(sr, en);
    chk("R8 write during busy ignored", sr, 8'h00);

    // R5: write-protect
    wren(); wrsr(8'h80); repeat (CYC) @(negedge clk);
    wpN = 1'b0;
    wren(); wrsr(8'h1C); repeat (CYC) @(negedge clk);
    readSr(sr, en);
    chk("R5 protected write rejected", sr, 8'h82);
    wpN = 1'b1;
    wrsr(8'h1C); repeat (CYC) @(negedge clk);
    readSr(sr, en);
    chk("R5 write after pin release", sr, 8'h1C);
    wpN = 1'b0;
    wren(); wrsr(8'h0C); repeat (CYC) @(negedge clk);
    readSr(sr, en);
    chk("R5 pin ignored with bit7 clear", sr, 8'h0C);
    wpN = 1'b1;

    // R2: streaming
    frame({8'h05, 24'h0}, 32, g, enA, en);
    chk("R2 repeated status byte", g[23:0], 24'h0C0C0C);
    chk("R9 misoEn after cs high", misoEn, 0);

    // R10: reset while idle
    wren();
    readSr(sr, en);
    chk("R10 enable before reset", sr, 8'h0E);
    hwRstN = 1'b0;
    repeat (20) @(negedge clk);
    frame(32'h0500, 16, g, enA, en);
    chk("R10 misoEn held low in reset", enA, 0);
    hwRstN = 1'b1;
    repeat (10) @(negedge clk);
    readSr(sr, en);
    chk("R10 reset clears enable keeps prot", sr, 8'h0C);

    // R11: reset during busy
    wren();
    wrsr(8'h9C);
    hwRstN = 1'b0;
    readSr(sr, en);
    chk("R11 cycle continues under reset", sr & 8'h03, 8'h03);
    repeat (CYC) @(negedge clk);
    hwRstN = 1'b1;
    repeat (10) @(negedge clk);
    readSr(sr, en);
    chk("R11 value after deferred reset", sr, 8'h9C);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule